// File: doc/BRIEF.md
# Video Event Interrupt Unit with Double-Buffered Settings

This block sits beside a video timing generator and turns its four timing strobes into one level-sensitive interrupt request for a system interrupt controller. Every strobe latches a sticky pending flag. A separate enable mask decides which flags drive the request line. Software services the block by reading the pending mask and writing the same value back. A pending bit clears only where a one is written, so an event that arrives between the read and the write-back survives.

The block also holds a bank of settings registers in two copies. Software writes the shadow copy at any point in the current frame. On the next start-of-field strobe, every shadow value moves into the active copy in a single clock. The active copy drives the `cfg_active` output, so the timing logic never sees a half-updated set. A status flag shows that written values are still waiting for that commit.

Top module: `vid_evt_irq_top`

## Requirements
- R1: Strobe bits map to pending bits as follows: bit 0 is line start, bit 1 is line end, bit 2 is field start and bit 3 is field end. A strobe sets its pending bit on the next clock edge whatever the enable mask holds. The pending mask reads at address 0 in bits [3:0].
- R2: A write to address 0 clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits as they were.
- R3: When a strobe and a clearing write reach the same pending bit in one cycle, the bit stays set.
- R4: `irq` is a register. It is high in every cycle where at least one bit position is set in both the enable mask and the pending mask. It changes on the same edge as those masks.
- R5: The enable mask is read and written at address 1 in bits [3:0]. A read presents `rd_data` with `rd_valid` high one cycle after `rd_en`.
- R6: Settings register i is written and read back at address 4+i, which targets the shadow copy. Its active copy, bits [16*i+15:16*i] of `cfg_active`, does not change except on a field-start strobe.
- R7: On a field-start strobe (strobe bit 2), all active copies take their shadow values on the same clock edge.
- R8: A shadow write in the same cycle as a field-start strobe is not committed by that strobe. It is committed by the next one.
- R9: Status bit 0 at address 2 becomes 1 after any shadow write. It returns to 0 on a field-start commit, unless a shadow write happens in that same cycle.
- R10: After reset, the pending mask, the enable mask, status, `irq`, every shadow copy and every active copy are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | 4 | One-cycle timing strobes: line start, line end, field start, field end |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | Marks rd_data as valid |
| irq | output | 1 | Level interrupt request |
| cfg_active | output | 64 | Active settings, register i in bits [16*i+15:16*i] |

## Verification
The bound checker watches several rules on every cycle: the request line matches enable AND pending, a strobe always leaves its pending bit set, a cleared bit stays clear unless a strobe hit it, active settings hold between field starts and take exactly the prior shadow values at a commit, and the status flag follows writes and commits. Other behaviours appear only in the bench's scenarios. These are the address map and the read data, the polled mode with a zero enable mask, and the case where a write and a commit land in the same cycle and the write is deferred to the following frame.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;
  localparam int ADDR_PEND_C   = 0;
  localparam int ADDR_ENABLE_C = 1;
  localparam int ADDR_STATUS_C = 2;
  localparam int CFG_BASE_C    = 4;
  localparam int EVT_LINE_START  = 0;
  localparam int EVT_LINE_END    = 1;
  localparam int EVT_FIELD_START = 2;
  localparam int EVT_FIELD_END   = 3;
endpackage

// File: rtl/vid_evt_pending.sv
module vid_evt_pending #(
  parameter int NEVT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEVT-1:0] evt,
  input  logic            clr_we,
  input  logic [NEVT-1:0] clr_mask,
  input  logic            en_we,
  input  logic [NEVT-1:0] en_data,
  output logic [NEVT-1:0] pend_q,
  output logic [NEVT-1:0] en_q,
  output logic            irq_q
);
  logic [NEVT-1:0] pend_next;
  logic [NEVT-1:0] en_next;

  always_comb begin
    pend_next = pend_q;
    if (clr_we) pend_next = pend_next & ~clr_mask;
    pend_next = pend_next | evt;             // an arriving event beats a clear
    en_next = en_we ? en_data : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_next;
      en_q   <= en_next;
      irq_q  <= |(pend_next & en_next);
    end
  end
endmodule

// File: rtl/vid_cfg_bank.sv
module vid_cfg_bank #(
  parameter int NREG  = 4,
  parameter int W     = 16,
  parameter int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [W-1:0]      wr_data,
  input  logic              commit,
  output logic [NREG*W-1:0] shadow_flat,
  output logic [NREG*W-1:0] active_flat,
  output logic              dirty
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [W-1:0] shadow_q;
    logic [W-1:0] active_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (wr_en && wr_idx == IDX_W'(g)) shadow_q <= wr_data;
        if (commit) active_q <= shadow_q;    // old shadow value: a same-cycle write waits a frame
      end
    end
    assign shadow_flat[g*W +: W] = shadow_q;
    assign active_flat[g*W +: W] = active_q;
  end

  always_ff @(posedge clk) begin
    if (rst) dirty <= 1'b0;
    else     dirty <= wr_en | (dirty & ~commit);
  end
endmodule

// File: rtl/vid_reg_rd.sv
module vid_reg_rd
  import vid_irq_pkg::*;
#(
  parameter int NEVT   = 4,
  parameter int NREG   = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [NEVT-1:0]        pend,
  input  logic [NEVT-1:0]        en,
  input  logic                   dirty,
  input  logic [NREG*DATA_W-1:0] shadow_flat,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_valid
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(ADDR_PEND_C);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADDR_ENABLE_C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS_C);
  localparam logic [ADDR_W-1:0] A_CFG0 = ADDR_W'(CFG_BASE_C);
  localparam logic [ADDR_W-1:0] A_CFGN = ADDR_W'(CFG_BASE_C + NREG);

  logic [ADDR_W-1:0] cfg_off;
  logic [DATA_W-1:0] mux;

  always_comb begin
    cfg_off = rd_addr - A_CFG0;
    mux = '0;
    if (rd_addr == A_PEND)      mux = {{(DATA_W-NEVT){1'b0}}, pend};
    else if (rd_addr == A_EN)   mux = {{(DATA_W-NEVT){1'b0}}, en};
    else if (rd_addr == A_STAT) mux = {{(DATA_W-1){1'b0}}, dirty};
    else if (rd_addr >= A_CFG0 && rd_addr < A_CFGN)
      mux = shadow_flat[cfg_off[IDX_W-1:0]*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mux;
    end
  end
endmodule

// File: rtl/vid_evt_irq_top.sv
module vid_evt_irq_top
  import vid_irq_pkg::*;
#(
  parameter int NEVT   = 4,
  parameter int NREG   = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NEVT-1:0]        evt_strobe,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_valid,
  output logic                   irq,
  output logic [NREG*DATA_W-1:0] cfg_active
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(ADDR_PEND_C);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADDR_ENABLE_C);
  localparam logic [ADDR_W-1:0] A_CFG0 = ADDR_W'(CFG_BASE_C);
  localparam logic [ADDR_W-1:0] A_CFGN = ADDR_W'(CFG_BASE_C + NREG);

  logic              wr_pend, wr_enable, wr_cfg, commit, dirty;
  logic [ADDR_W-1:0] wr_off;
  logic [NEVT-1:0]   pend_q, en_q;
  logic [NREG*DATA_W-1:0] shadow_flat;

  assign wr_pend   = wr_en && (wr_addr == A_PEND);
  assign wr_enable = wr_en && (wr_addr == A_EN);
  assign wr_cfg    = wr_en && (wr_addr >= A_CFG0) && (wr_addr < A_CFGN);
  assign wr_off    = wr_addr - A_CFG0;
  assign commit    = evt_strobe[EVT_FIELD_START];

  vid_evt_pending #(.NEVT(NEVT)) u_pend (
    .clk(clk), .rst(rst), .evt(evt_strobe),
    .clr_we(wr_pend), .clr_mask(wr_data[NEVT-1:0]),
    .en_we(wr_enable), .en_data(wr_data[NEVT-1:0]),
    .pend_q(pend_q), .en_q(en_q), .irq_q(irq)
  );

  vid_cfg_bank #(.NREG(NREG), .W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_cfg), .wr_idx(wr_off[IDX_W-1:0]),
    .wr_data(wr_data), .commit(commit),
    .shadow_flat(shadow_flat), .active_flat(cfg_active), .dirty(dirty)
  );

  vid_reg_rd #(.NEVT(NEVT), .NREG(NREG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .pend(pend_q), .en(en_q), .dirty(dirty), .shadow_flat(shadow_flat),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/vid_irq_checker.sv
module vid_irq_checker
  import vid_irq_pkg::*;
#(
  parameter int NEVT   = 4,
  parameter int NREG   = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NEVT-1:0]        evt_strobe,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [DATA_W-1:0]      wr_data,
  input logic                   irq,
  input logic [NEVT-1:0]        pend_q,
  input logic [NEVT-1:0]        en_q,
  input logic                   dirty,
  input logic [NREG*DATA_W-1:0] shadow_flat,
  input logic [NREG*DATA_W-1:0] cfg_active
);
  logic            clr_now, cfg_now, fs_now;
  logic [NEVT-1:0] clr_only;
  assign clr_now  = wr_en && (wr_addr == ADDR_W'(ADDR_PEND_C));
  assign cfg_now  = wr_en && (wr_addr >= ADDR_W'(CFG_BASE_C)) &&
                    (wr_addr < ADDR_W'(CFG_BASE_C + NREG));
  assign fs_now   = evt_strobe[EVT_FIELD_START];
  assign clr_only = wr_data[NEVT-1:0] & ~evt_strobe;

  assert_evt_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (evt_strobe != '0) |=> ((pend_q & $past(evt_strobe)) == $past(evt_strobe)));

  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (clr_now && clr_only != '0) |=> ((pend_q & $past(clr_only)) == '0));

  assert_irq_level_R4: assert property (@(posedge clk) disable iff (rst)
    irq == |(en_q & pend_q));

  assert_active_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !fs_now |=> $stable(cfg_active));

  assert_commit_copy_R7: assert property (@(posedge clk) disable iff (rst)
    fs_now |=> (cfg_active == $past(shadow_flat)));

  assert_status_set_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_now |=> dirty);

  assert_status_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (fs_now && !cfg_now) |=> !dirty);
endmodule

bind vid_evt_irq_top vid_irq_checker #(
  .NEVT(NEVT), .NREG(NREG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .evt_strobe(evt_strobe), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .pend_q(pend_q),
  .en_q(en_q), .dirty(dirty), .shadow_flat(shadow_flat), .cfg_active(cfg_active)
);

// File: tb/sim_vid_evt_irq_top.sv
module sim_vid_evt_irq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  evt_strobe = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        irq;
  logic [63:0] cfg_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  vid_evt_irq_top u0 (
    .clk(clk), .rst(rst), .evt_strobe(evt_strobe), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq), .cfg_active(cfg_active)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle, called at a falling edge, returns at the next falling edge
  task automatic cyc(input logic we, input logic [3:0] a, input logic [15:0] d,
                     input logic [3:0] ev);
    wr_en = we; wr_addr = a; wr_data = d; evt_strobe = ev;
    @(negedge clk);
    wr_en = 1'b0; evt_strobe = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("read without expectation", 64'(rd_data), 64'hx);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, 64'(rd_data), 64'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 irq after reset", 64'(irq), 0);
    check("R10 active after reset", cfg_active, 0);
    rd(4'd0, 16'h0, "R10 pending after reset");
    rd(4'd1, 16'h0, "R10 R5 enable after reset");
    rd(4'd2, 16'h0, "R10 status after reset");
    rd(4'd5, 16'h0, "R10 shadow after reset");

    // R1 polled mode: enable zero, events still latch
    cyc(1'b0, 4'd0, 16'h0, 4'b0001);
    check("R1 irq stays low with enable zero", 64'(irq), 0);
    rd(4'd0, 16'h0001, "R1 line start latched");
    cyc(1'b0, 4'd0, 16'h0, 4'b1000);
    rd(4'd0, 16'h0009, "R1 field end latched");

    // R4 / R5 enable
    cyc(1'b1, 4'd1, 16'h0001, 4'b0000);
    check("R4 irq with enabled pending", 64'(irq), 1);
    rd(4'd1, 16'h0001, "R5 enable read back");

    // R2 write-one-to-clear
    cyc(1'b1, 4'd0, 16'h0000, 4'b0000);
    rd(4'd0, 16'h0009, "R2 zeros leave pending");
    cyc(1'b1, 4'd0, 16'h0008, 4'b0000);
    rd(4'd0, 16'h0001, "R2 clear field end only");
    check("R4 irq still high", 64'(irq), 1);
    cyc(1'b1, 4'd0, 16'h0001, 4'b0000);
    check("R4 irq drops on clear", 64'(irq), 0);
    rd(4'd0, 16'h0000, "R2 all clear");

    // R3 event beats clear in the same cycle
    cyc(1'b1, 4'd0, 16'h0002, 4'b0010);
    rd(4'd0, 16'h0002, "R3 event wins over clear");
    cyc(1'b1, 4'd0, 16'h0002, 4'b0000);

    // R6 shadow writes do not reach active
    cyc(1'b1, 4'd4, 16'h1234, 4'b0000);
    cyc(1'b1, 4'd7, 16'hBEEF, 4'b0000);
    check("R6 active unchanged after write", cfg_active, 0);
    rd(4'd4, 16'h1234, "R6 shadow 0 read back");
    rd(4'd7, 16'hBEEF, "R6 shadow 3 read back");
    rd(4'd2, 16'h0001, "R9 status set after write");

    // R7 commit on field start, with field-start interrupt enabled
    cyc(1'b1, 4'd1, 16'h0004, 4'b0000);
    cyc(1'b0, 4'd0, 16'h0, 4'b0100);
    check("R7 commit all registers", cfg_active, 64'hBEEF_0000_0000_1234);
    check("R4 irq on enabled field start", 64'(irq), 1);
    rd(4'd2, 16'h0000, "R9 status cleared on commit");
    rd(4'd0, 16'h0004, "R1 field start latched");
    cyc(1'b1, 4'd0, 16'h0004, 4'b0000);

    // R8 write landing with the commit waits one frame
    cyc(1'b1, 4'd5, 16'h5555, 4'b0100);
    check("R8 same-cycle write not committed", cfg_active, 64'hBEEF_0000_0000_1234);
    rd(4'd2, 16'h0001, "R9 status kept by same-cycle write");
    repeat (3) @(negedge clk);
    check("R6 active holds between fields", cfg_active, 64'hBEEF_0000_0000_1234);
    cyc(1'b0, 4'd0, 16'h0, 4'b0100);
    check("R8 committed at next field", cfg_active, 64'hBEEF_0000_5555_1234);
    rd(4'd2, 16'h0000, "R9 status clear after second commit");

    repeat (3) @(negedge clk);
    check("read queue drained", 64'(exp_q.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule